// File: doc/BRIEF.md
# Software Trap Entry Sequencer

This block carries out the register changes that take place when a software trap instruction executes. The pipeline presents a one-cycle request together with three values: the address of the trap instruction, the current status word and the 5-bit vector taken from the instruction. One clock later the block raises a single-cycle commit strobe. In that cycle it presents, as write data, every register the trap changes.

The saved-PC register receives the address just past the trap instruction. The trap instruction is 32 bits long, so this is the instruction's address plus 4. The saved-status register receives the status word exactly as it was. The interrupt-code field of the cause register receives 0x40 plus the vector number. The new status word is the old one with the exception-pending and interrupt-disable bits set. The new program counter is one of two fixed handler entry points, and the top bit of the vector selects which one.

The register file and the status and cause registers sit outside the block. They capture the write data when commit is high. Between trap requests the write outputs hold their last values.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset (rst_n low) is applied, and in the first cycle after it, commit is 0 and every write output is zero.
- R2: commit is 1 in the cycle after each cycle in which trap_req is 1, and 0 in every other cycle. Back-to-back requests give back-to-back commits.
- R3: In a commit cycle, epc_wdata equals the trap_pc of the request plus 4, taken modulo 2^32, so 0xFFFFFFFC gives 0x00000000.
- R4: In a commit cycle, epsw_wdata equals the trap_psw of the request, all 32 bits unchanged.
- R5: In a commit cycle, cause_code_wdata equals 0x0040 plus the request's trap_vec. This gives 0x0040 to 0x005F.
- R6: In a commit cycle, pc_wdata is 0x00000040 when trap_vec bit 4 is 0 (vectors 0x00 to 0x0F), and 0x00000050 when it is 1 (vectors 0x10 to 0x1F).
- R7: In a commit cycle, psw_wdata has bit 5 (interrupt-disable) and bit 6 (exception-pending) set to 1. All other bits equal the request's trap_psw.
- R8: In a cycle without commit, every write output keeps the value it had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | One-cycle request: a trap instruction executes |
| trap_pc | input | 32 | Address of the trap instruction |
| trap_psw | input | 32 | Current status word |
| trap_vec | input | 5 | Vector field of the trap instruction |
| commit | output | 1 | Single-cycle strobe: all write data valid |
| epc_wdata | output | 32 | Write data for the saved-PC register |
| epsw_wdata | output | 32 | Write data for the saved-status register |
| cause_code_wdata | output | 16 | Write data for the interrupt-code field of the cause register |
| psw_wdata | output | 32 | New status word |
| pc_wdata | output | 32 | New program counter (handler entry) |

## Verification
The bench drives the vectors on both sides of the entry-point boundary: 0x0F and 0x10, as well as 0x00 and 0x1F. A design that decoded the wrong vector bit would send one of these to the wrong handler. It would also produce a wrong code at the ends of the code range.

A trap at address 0xFFFFFFFC checks that the return address wraps to zero. Status words of all zeros, all ones and alternating bits show whether the two forced bits land in the right places. They also show whether any other bit is altered or lost.

Back-to-back requests and idle gaps are mixed. A design that merged two commits, stretched the strobe or let the outputs drift while idle would show a difference from the reference model in the cycle where it occurs.

// File: rtl/trap_pkg.sv
// Package trap_pkg
// Holds the widths shared by the trap entry logic and the record that
// gathers every register write one trap produces.
// Assumes a 32-bit machine with a 5-bit vector field.
package trap_pkg;
    parameter int XLEN   = 32;
    parameter int VEC_W  = 5;
    parameter int CODE_W = 16;

    typedef struct packed {
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   epsw;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   psw;
        logic [XLEN-1:0]   pc;
    } trap_writes_t;
endpackage

// File: rtl/trap_vector_decode.sv
// Module trap_vector_decode
// Purely combinational. Turns the vector field into the interrupt code and
// the handler entry address. The top vector bit picks one of two entries.
// Assumes CODE_BASE plus the largest vector fits in CODE_W bits.
module trap_vector_decode #(
    parameter int VEC_W      = 5,
    parameter int ADDR_W     = 32,
    parameter int CODE_W     = 16,
    parameter logic [CODE_W-1:0] CODE_BASE  = 16'h0040,
    parameter logic [ADDR_W-1:0] LOW_ENTRY  = 32'h0000_0040,
    parameter logic [ADDR_W-1:0] HIGH_ENTRY = 32'h0000_0050
) (
    input  logic [VEC_W-1:0]  vec,
    output logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] entry
);
    localparam int PAD_W = CODE_W - VEC_W;

    // Interrupt code: base plus the zero-extended vector.
    always_comb begin
        code = CODE_BASE + {{PAD_W{1'b0}}, vec};
    end

    // Entry selection on the upper vector bit.
    always_comb begin
        entry = vec[VEC_W-1] ? HIGH_ENTRY : LOW_ENTRY;
    end
endmodule

// File: rtl/trap_status_update.sv
// Module trap_status_update
// Purely combinational. Builds the new status word: the two forced bits
// are set, every other bit passes through.
// Assumes SET_A and SET_B are distinct positions below WIDTH.
module trap_status_update #(
    parameter int WIDTH = 32,
    parameter int SET_A = 5,
    parameter int SET_B = 6
) (
    input  logic [WIDTH-1:0] psw_in,
    output logic [WIDTH-1:0] psw_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == SET_A || i == SET_B) begin : g_force
            // Forced status bit.
            assign psw_out[i] = 1'b1;
        end else begin : g_pass
            // Untouched status bit.
            assign psw_out[i] = psw_in[i];
        end
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Module trap_entry_seq
// Top level of the software trap entry sequencer. It samples a trap request
// and, one cycle later, presents every register write together with a
// one-cycle commit strobe. The write data holds between requests.
// Assumes trap_pc, trap_psw and trap_vec are valid whenever trap_req is high.
module trap_entry_seq
    import trap_pkg::*;
#(
    parameter int INSTR_BYTES = 4,
    parameter int ID_BIT      = 5,
    parameter int EP_BIT      = 6,
    parameter logic [CODE_W-1:0] CODE_BASE  = 16'h0040,
    parameter logic [XLEN-1:0]   LOW_ENTRY  = 32'h0000_0040,
    parameter logic [XLEN-1:0]   HIGH_ENTRY = 32'h0000_0050
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_psw,
    input  logic [VEC_W-1:0]  trap_vec,
    output logic              commit,
    output logic [XLEN-1:0]   epc_wdata,
    output logic [XLEN-1:0]   epsw_wdata,
    output logic [CODE_W-1:0] cause_code_wdata,
    output logic [XLEN-1:0]   psw_wdata,
    output logic [XLEN-1:0]   pc_wdata
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    trap_writes_t next_w, held_w;
    logic [CODE_W-1:0] dec_code;
    logic [XLEN-1:0]   dec_entry;
    logic [XLEN-1:0]   upd_psw;

    trap_vector_decode #(
        .VEC_W(VEC_W), .ADDR_W(XLEN), .CODE_W(CODE_W),
        .CODE_BASE(CODE_BASE), .LOW_ENTRY(LOW_ENTRY), .HIGH_ENTRY(HIGH_ENTRY)
    ) u_decode (
        .vec(trap_vec), .code(dec_code), .entry(dec_entry)
    );

    trap_status_update #(
        .WIDTH(XLEN), .SET_A(ID_BIT), .SET_B(EP_BIT)
    ) u_status (
        .psw_in(trap_psw), .psw_out(upd_psw)
    );

    // Assemble the full write record for the request now presented.
    always_comb begin
        next_w.epc  = trap_pc + STEP;
        next_w.epsw = trap_psw;
        next_w.code = dec_code;
        next_w.psw  = upd_psw;
        next_w.pc   = dec_entry;
    end

    // Capture the write record on a request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        held_w <= '0;
        else if (trap_req) held_w <= next_w;
    end

    // One-cycle commit strobe, one per request.
    always_ff @(posedge clk) begin
        if (!rst_n) commit <= 1'b0;
        else        commit <= trap_req;
    end

    // Drive the register write ports.
    always_comb begin
        epc_wdata        = held_w.epc;
        epsw_wdata       = held_w.epsw;
        cause_code_wdata = held_w.code;
        psw_wdata        = held_w.psw;
        pc_wdata         = held_w.pc;
    end
endmodule

// File: rtl/trap_entry_seq_checker.sv
// Module trap_entry_seq_checker
// Protocol and data properties of the trap entry sequencer. It is bound to
// every instance of the top level.
// Assumes the default bit positions and entry addresses.
module trap_entry_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_req,
    input logic [31:0] trap_pc,
    input logic [31:0] trap_psw,
    input logic [4:0]  trap_vec,
    input logic        commit,
    input logic [31:0] epc_wdata,
    input logic [31:0] epsw_wdata,
    input logic [15:0] cause_code_wdata,
    input logic [31:0] psw_wdata,
    input logic [31:0] pc_wdata
);
    assert_commit_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> commit);
    assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> !commit);
    assert_return_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (epc_wdata == $past(trap_pc) + 32'd4));
    assert_saved_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (epsw_wdata == $past(trap_psw)));
    assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cause_code_wdata >= 16'h0040 && cause_code_wdata <= 16'h005F));
    assert_entry_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (pc_wdata == ($past(trap_vec[4]) ? 32'h50 : 32'h40)));
    assert_status_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (psw_wdata[5] && psw_wdata[6]));
    assert_status_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((psw_wdata & ~32'h60) == (epsw_wdata & ~32'h60)));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !commit) |-> ($stable(epc_wdata) && $stable(pc_wdata)
            && $stable(psw_wdata) && $stable(epsw_wdata) && $stable(cause_code_wdata)));
endmodule

bind trap_entry_seq trap_entry_seq_checker u_checker (.*);

// File: tb/trap_entry_seq_bench.sv
// Bench for trap_entry_seq: a behavioural reference model stepped on every
// rising edge and compared against the outputs on every falling edge.
module trap_entry_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_psw = '0;
    logic [4:0]  trap_vec = '0;
    logic        commit;
    logic [31:0] epc_wdata, epsw_wdata, psw_wdata, pc_wdata;
    logic [15:0] cause_code_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state
    logic        m_commit = 1'b0;
    logic [31:0] m_epc = '0, m_epsw = '0, m_psw = '0, m_pc = '0;
    logic [15:0] m_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_seq u_trap_entry_seq (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_pc(trap_pc),
        .trap_psw(trap_psw), .trap_vec(trap_vec), .commit(commit),
        .epc_wdata(epc_wdata), .epsw_wdata(epsw_wdata),
        .cause_code_wdata(cause_code_wdata), .psw_wdata(psw_wdata),
        .pc_wdata(pc_wdata)
    );

    // Reference model step, written from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_commit <= 1'b0;
            m_epc <= '0; m_epsw <= '0; m_code <= '0; m_psw <= '0; m_pc <= '0;
        end else begin
            m_commit <= trap_req;
            if (trap_req) begin
                m_epc  <= trap_pc + 32'd4;
                m_epsw <= trap_psw;
                m_code <= 16'h0040 + 16'(trap_vec);
                m_psw  <= trap_psw | 32'h0000_0060;
                m_pc   <= (trap_vec >= 5'h10) ? 32'h0000_0050 : 32'h0000_0040;
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Compare every field on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            string t;
            t = !rst_n ? "R1" : "R2";
            check({t, " commit"}, 32'(commit), 32'(m_commit));
            check(m_commit ? "R3 epc" : "R8 epc", epc_wdata, m_epc);
            check(m_commit ? "R4 epsw" : "R8 epsw", epsw_wdata, m_epsw);
            check(m_commit ? "R5 code" : "R8 code", 32'(cause_code_wdata), 32'(m_code));
            check(m_commit ? "R7 psw" : "R8 psw", psw_wdata, m_psw);
            check(m_commit ? "R6 pc" : "R8 pc", pc_wdata, m_pc);
        end
    end

    task automatic trap(logic [31:0] pc, logic [31:0] psw, logic [4:0] v);
        @(negedge clk);
        #1;
        trap_req = 1'b1; trap_pc = pc; trap_psw = psw; trap_vec = v;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            trap_req = 1'b0;
            trap_pc = $urandom; trap_psw = $urandom; trap_vec = 5'($urandom);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        // R6 boundary vectors and R5 code extremes
        trap(32'h0000_1000, 32'h0000_0000, 5'h00); idle(1);
        trap(32'h0000_2000, 32'hFFFF_FFFF, 5'h0F); idle(2);
        trap(32'h0000_3000, 32'hAAAA_AAAA, 5'h10); idle(1);
        trap(32'h0000_4000, 32'h5555_5555, 5'h1F); idle(1);
        // R3 wrap of return address
        trap(32'hFFFF_FFFC, 32'h1234_5678, 5'h07); idle(1);
        // R2 back-to-back requests
        trap(32'h0000_0100, 32'h0000_0060, 5'h11);
        trap(32'h0000_0200, 32'hFFFF_FF9F, 5'h02);
        trap(32'h0000_0300, 32'h8000_0001, 5'h1E);
        idle(3);
        // R4/R7 varied status words, random traffic
        for (int k = 0; k < 60; k++) begin
            trap($urandom, $urandom, 5'($urandom));
            idle(k % 3);
        end
        // R1 reset in mid-run
        @(negedge clk); #1 rst_n = 1'b0; trap_req = 1'b1;
        idle(2);
        @(negedge clk); #1 rst_n = 1'b1;
        idle(2);
        trap(32'h0000_0ABC, 32'h0F0F_0F0F, 5'h13); idle(3);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule